// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block sequences the two secondary-side rectifier switches of a forward converter: the forward switch, which conducts while the primary delivers power, and the catch switch, which carries the inductor current while the primary is off. Two comparators ahead of it qualify the sync pulses that cross the isolation barrier. Each comparator presents one level flag, one for positive-going pulses and one for negative-going pulses. The block acts on the rising edge of each flag, and the gate states it sets hold between pulses.

Three protections guard the switches. A missing-sync timer forces both gates off when the sync stream stops or loses its alternation. A reverse-current flag turns the catch switch off once a blanking interval has passed. An undervoltage flag holds both gates off. All intervals are parameters counted in clock cycles: `TMO_CYCLES` sets the timeout (about one switching period, or zero to disable it), `BLANK_CYCLES` sets the blanking interval, and `CLR_CYCLES` sets the length of the timer clear pulse.

Top module: `sr_gate_seq`

## Requirements
- R1: A rising edge on `sync_neg` alone sets `fwd_gate` high and `catch_gate` low from the cycle after the clock edge that samples it, unless the gates are masked by R6, R9 or R10.
- R2: A rising edge on `sync_pos` alone sets `fwd_gate` low and `catch_gate` high from the cycle after the clock edge that samples it, unless the gates are masked by R6, R9 or R10.
- R3: Rising edges on both sync flags at the same clock edge are ignored. They change no gate and do not clear the timer. `fwd_gate` and `catch_gate` are never high together.
- R4: With no sync edges, the gates keep the state set by the last accepted edge.
- R5: The timer is cleared only by an accepted negative edge that follows an accepted positive edge since the previous accepted negative edge or since reset. A clear holds the count at zero for `CLR_CYCLES` cycles, after which the count resumes.
- R6: With `TMO_CYCLES` > 0, both gates are low while the count equals `TMO_CYCLES`. The count grows by one per cycle and saturates there. The next clear under R5 restores normal switching.
- R7: With `TMO_CYCLES` = 0 the timeout never forces the gates.
- R8: `rev_trip` is ignored until `catch_gate` has been high at more than `BLANK_CYCLES` consecutive clock edges. After that, a sampled `rev_trip` drives `catch_gate` low from the next cycle.
- R9: A reverse-current shutdown keeps `catch_gate` low through later positive edges. Only the next accepted negative edge clears it.
- R10: While `uv_low` is high, both gates are low in the same cycle. The sequencing state keeps updating underneath.
- R11: A synchronous active-high `rst` drives both gates low, discards the last polarity, starts the timer count at zero and requires a positive edge before a timer clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_pos | input | 1 | Qualified positive sync pulse flag |
| sync_neg | input | 1 | Qualified negative sync pulse flag |
| rev_trip | input | 1 | Reverse current comparator flag |
| uv_low | input | 1 | Supply undervoltage flag |
| fwd_gate | output | 1 | Forward switch gate enable |
| catch_gate | output | 1 | Catch switch gate enable |

## Verification
Five properties hold on every cycle:
- the gates are never high together;
- undervoltage keeps both gates low;
- a lone negative edge leaves the catch gate off in the next cycle;
- a lone positive edge leaves the forward gate off in the next cycle;
- a reverse-current shutdown never cuts a catch-on run shorter than the blanking interval.

Only the bench scenarios can show the remaining behaviour, using a reference model that compares both outputs every cycle. These scenarios cover the alternation rule of the timer clear, expiry after a repeated negative pulse, recovery, the disabled-timeout variant, the persistence of a shutdown through a later positive edge, and reset in mid-operation.

// File: rtl/sr_gate_seq.sv
module sr_gate_seq #(
  parameter int TMO_CYCLES   = 1250,
  parameter int BLANK_CYCLES = 31,
  parameter int CLR_CYCLES   = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_pos,
  input  logic sync_neg,
  input  logic rev_trip,
  input  logic uv_low,
  output logic fwd_gate,
  output logic catch_gate
);
  localparam int BW = (BLANK_CYCLES > 0) ? $clog2(BLANK_CYCLES + 1) : 1;

  logic pos_q, neg_q;
  logic rise_p, rise_n, pos_ev, neg_ev;
  logic drive_fwd, drive_catch, armed, rc_off, expired;
  logic [BW-1:0] blank_cnt;
  logic blank_done, trip;

  assign rise_p = sync_pos & ~pos_q;
  assign rise_n = sync_neg & ~neg_q;
  assign pos_ev = rise_p & ~rise_n;
  assign neg_ev = rise_n & ~rise_p;

  assign fwd_gate   = drive_fwd & ~uv_low & ~expired;
  assign catch_gate = drive_catch & ~rc_off & ~uv_low & ~expired;

  assign blank_done = (blank_cnt == BW'(BLANK_CYCLES));
  assign trip       = catch_gate & blank_done & rev_trip;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      pos_q <= sync_pos;
      neg_q <= sync_neg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_fwd   <= 1'b0;
      drive_catch <= 1'b0;
      armed       <= 1'b0;
    end else if (neg_ev) begin
      drive_fwd   <= 1'b1;
      drive_catch <= 1'b0;
      armed       <= 1'b0;
    end else if (pos_ev) begin
      drive_fwd   <= 1'b0;
      drive_catch <= 1'b1;
      armed       <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rc_off <= 1'b0;
    else if (neg_ev)
      rc_off <= 1'b0;
    else if (trip)
      rc_off <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !catch_gate)
      blank_cnt <= '0;
    else if (!blank_done)
      blank_cnt <= blank_cnt + 1'b1;
  end

  generate
    if (TMO_CYCLES > 0) begin : g_tmo
      localparam int TW = $clog2(TMO_CYCLES + 1);
      localparam int CW = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;
      logic [TW-1:0] tmo_cnt;
      logic [CW-1:0] clr_rem;
      logic clr_ev;

      assign clr_ev  = neg_ev & armed;
      assign expired = (tmo_cnt == TW'(TMO_CYCLES));

      always_ff @(posedge clk) begin
        if (rst) begin
          tmo_cnt <= '0;
          clr_rem <= '0;
        end else if (clr_ev) begin
          tmo_cnt <= '0;
          clr_rem <= CW'(CLR_CYCLES - 1);
        end else if (clr_rem != '0) begin
          tmo_cnt <= '0;
          clr_rem <= clr_rem - 1'b1;
        end else if (!expired) begin
          tmo_cnt <= tmo_cnt + 1'b1;
        end
      end
    end else begin : g_no_tmo
      assign expired = 1'b0;
    end
  endgenerate
endmodule

module sr_gate_seq_chk #(
  parameter int BLANK_CYCLES = 31
) (
  input logic clk,
  input logic rst,
  input logic sync_pos,
  input logic sync_neg,
  input logic pos_q,
  input logic neg_q,
  input logic uv_low,
  input logic rc_off,
  input logic fwd_gate,
  input logic catch_gate
);
  localparam int RW  = $clog2(BLANK_CYCLES + 3);
  localparam int LIM = BLANK_CYCLES + 1;

  logic [RW-1:0] run;
  logic lone_neg, lone_pos;

  assign lone_neg = sync_neg & ~neg_q & ~(sync_pos & ~pos_q);
  assign lone_pos = sync_pos & ~pos_q & ~(sync_neg & ~neg_q);

  always_ff @(posedge clk) begin
    if (rst || !catch_gate)
      run <= '0;
    else if (run != RW'(LIM))
      run <= run + 1'b1;
  end

  p_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(fwd_gate && catch_gate));

  p_uv_off_r10: assert property (@(posedge clk) disable iff (rst)
    uv_low |-> (!fwd_gate && !catch_gate));

  p_neg_catch_off_r1: assert property (@(posedge clk) disable iff (rst)
    lone_neg |=> !catch_gate);

  p_pos_fwd_off_r2: assert property (@(posedge clk) disable iff (rst)
    lone_pos |=> !fwd_gate);

  p_blank_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(catch_gate) && (run < RW'(LIM))) |-> !rc_off);
endmodule

bind sr_gate_seq sr_gate_seq_chk #(.BLANK_CYCLES(BLANK_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .sync_pos(sync_pos), .sync_neg(sync_neg),
  .pos_q(pos_q), .neg_q(neg_q), .uv_low(uv_low), .rc_off(rc_off),
  .fwd_gate(fwd_gate), .catch_gate(catch_gate)
);

// File: tb/tb_sr_gate_seq.sv
module tb_sr_gate_seq;
  localparam int TMO = 200;
  localparam int BLK = 6;
  localparam int CLR = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, sp, sn, rv, uv;
  logic fwd0, cat0, fwd1, cat1;

  sr_gate_seq #(.TMO_CYCLES(TMO), .BLANK_CYCLES(BLK), .CLR_CYCLES(CLR)) dut (
    .clk(clk), .rst(rst), .sync_pos(sp), .sync_neg(sn), .rev_trip(rv),
    .uv_low(uv), .fwd_gate(fwd0), .catch_gate(cat0));

  sr_gate_seq #(.TMO_CYCLES(0), .BLANK_CYCLES(BLK), .CLR_CYCLES(CLR)) dut_off (
    .clk(clk), .rst(rst), .sync_pos(sp), .sync_neg(sn), .rev_trip(rv),
    .uv_low(uv), .fwd_gate(fwd1), .catch_gate(cat1));

  int errors = 0;
  int checks = 0;
  string tag = "R11";
  bit done = 0;

  // Reference model: cmd 0 none, 1 forward, 2 catch
  int m_cmd[2], m_arm[2], m_t[2], m_clr[2], m_run[2], m_rc[2];
  int lim[2] = '{TMO, 0};
  bit ppos, pneg;

  function automatic bit m_exp(int i);
    return lim[i] > 0 && m_t[i] == lim[i];
  endfunction
  function automatic bit m_fwd(int i);
    return m_cmd[i] == 1 && !uv && !m_exp(i);
  endfunction
  function automatic bit m_cat(int i);
    return m_cmd[i] == 2 && m_rc[i] == 0 && !uv && !m_exp(i);
  endfunction

  always @(posedge clk) begin : model
    bit rp, rn, pe, ne, c, trip;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_cmd[i] = 0; m_arm[i] = 0; m_t[i] = 0;
        m_clr[i] = 0; m_run[i] = 0; m_rc[i] = 0;
      end
      ppos = 0; pneg = 0;
    end else begin
      rp = sp && !ppos;
      rn = sn && !pneg;
      pe = rp && !rn;
      ne = rn && !rp;
      for (int i = 0; i < 2; i++) begin
        c = m_cat(i);
        trip = c && m_run[i] >= BLK && rv;
        m_run[i] = c ? m_run[i] + 1 : 0;
        if (ne) m_rc[i] = 0;
        else if (trip) m_rc[i] = 1;
        if (ne && m_arm[i] == 1) begin
          m_t[i] = 0; m_clr[i] = CLR - 1;
        end else if (m_clr[i] > 0) begin
          m_t[i] = 0; m_clr[i] = m_clr[i] - 1;
        end else if (lim[i] > 0 && m_t[i] < lim[i]) begin
          m_t[i] = m_t[i] + 1;
        end
        if (pe) begin m_arm[i] = 1; m_cmd[i] = 2; end
        if (ne) begin m_arm[i] = 0; m_cmd[i] = 1; end
      end
      ppos = sp;
      pneg = sn;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (fwd0 !== m_fwd(0) || cat0 !== m_cat(0)) begin
        errors++;
        $display("FAIL %s dut fwd=%b exp=%b catch=%b exp=%b", tag, fwd0, m_fwd(0), cat0, m_cat(0));
      end
      checks++;
      if (fwd1 !== m_fwd(1) || cat1 !== m_cat(1)) begin
        errors++;
        $display("FAIL %s R7 dut_off fwd=%b exp=%b catch=%b exp=%b", tag, fwd1, m_fwd(1), cat1, m_cat(1));
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic pulse_neg();
    sn = 1; step(2); sn = 0; step(1);
  endtask
  task automatic pulse_pos();
    sp = 1; step(2); sp = 0; step(1);
  endtask

  initial begin
    rst = 1; sp = 0; sn = 0; rv = 0; uv = 0;
    step(3);
    rst = 0;
    tag = "R11"; step(5);
    tag = "R1"; pulse_neg(); step(20);
    tag = "R2"; pulse_pos(); step(20);
    tag = "R4";
    for (int k = 0; k < 4; k++) begin
      pulse_neg(); step(30); pulse_pos(); step(30);
    end
    tag = "R3"; sp = 1; sn = 1; step(2); sp = 0; sn = 0; step(10);
    tag = "R5"; pulse_neg(); step(20); pulse_pos(); step(10);
    pulse_neg(); step(150);
    pulse_neg(); step(40);
    tag = "R6"; step(80);
    pulse_pos(); step(20);
    pulse_neg(); step(20);
    tag = "R8"; pulse_pos();
    rv = 1; step(2); rv = 0; step(10);
    rv = 1; step(3); rv = 0; step(5);
    tag = "R9"; pulse_pos(); step(10);
    pulse_neg(); step(10);
    pulse_pos(); step(10);
    tag = "R10"; uv = 1; step(5); uv = 0; step(5);
    pulse_neg(); step(5); uv = 1; step(3); uv = 0; step(10);
    tag = "R11"; rst = 1; step(2); rst = 0; step(8);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule